// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address, a segment number with an offset inside that segment, into a physical address. It looks the segment up in a small table held in registers. Each table entry carries a base physical address, a segment length, a validation bit and three access rights: read, write and instruction fetch. A length register sets how many segment numbers are legal.

A request is a segment number, an offset and an access type. One cycle later the block returns either a physical address or exactly one fault flag. There are three flags: illegal segment, offset out of range, and permission violation. The table and the length register are loaded through a programming port. A write through that port takes effect only when the port's privilege qualifier is set.

Top module: `seg_xlate_unit`

## Requirements
- R1: While rst_ni is low and after its release, rsp_valid_o, rsp_paddr_o and all fault flags are 0. The length register resets to 0 and every entry resets to invalid, so a first request faults as an illegal segment.
- R2: A request presented with req_valid_i=1 at a clock edge produces rsp_valid_o=1 after that edge, for exactly one cycle per request. Without a request, rsp_valid_o, rsp_paddr_o and the flags are 0.
- R3: A segment number equal to or greater than the length register raises fault_seg_o. This check has the highest priority.
- R4: A segment whose entry has its validation bit at 0 raises fault_seg_o. This check ranks below R3.
- R5: An offset equal to or greater than the entry's limit raises fault_range_o. This check ranks below R4.
- R6: req_acc_i codes are 0 for read, 1 for write, 2 for fetch and 3 for reserved. cfg_perm_i bit 0 grants read, bit 1 grants write and bit 2 grants fetch. An access without its right, or any access using code 3, raises fault_perm_o. This check ranks lowest.
- R7: A request that passes every check returns rsp_paddr_o = base + offset, modulo 2^PA_W, with no flag raised.
- R8: At most one fault flag is set at a time, and rsp_paddr_o is 0 whenever a flag is set.
- R9: A write through the programming port happens only when cfg_we_i and cfg_priv_i are both 1. With cfg_len_sel_i=1 it loads the length register from cfg_len_i. With cfg_len_sel_i=0 it loads entry cfg_idx_i. A request made in the same cycle as a write still sees the old contents.
- R10: The length register spans 0 to SEG_CNT. With length 8 segment 7 is legal; with length 7 segment 7 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_seg_i | input | SEG_W (3) | Segment number |
| req_off_i | input | OFF_W (12) | Offset within the segment |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| cfg_we_i | input | 1 | Programming write strobe |
| cfg_priv_i | input | 1 | Privilege qualifier for programming writes |
| cfg_len_sel_i | input | 1 | 1 selects the length register, 0 selects a table entry |
| cfg_idx_i | input | SEG_W (3) | Entry index for an entry write |
| cfg_base_i | input | PA_W (16) | Entry base address |
| cfg_limit_i | input | OFF_W+1 (13) | Entry segment length |
| cfg_valid_i | input | 1 | Entry validation bit |
| cfg_perm_i | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 fetch |
| cfg_len_i | input | LEN_W (4) | New value for the length register |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_paddr_o | output | PA_W (16) | Physical address, 0 on a fault |
| fault_seg_o | output | 1 | Illegal segment: beyond the length or an invalid entry |
| fault_range_o | output | 1 | Offset not below the limit |
| fault_perm_o | output | 1 | Access type not permitted |

## Verification
The assertions check four things on every cycle. The response strobe follows the request by exactly one cycle. No more than one fault flag is set, and a fault always carries a zero address. Any segment number at or above the length register leads to a segment fault. An unprivileged write leaves the length register unchanged.

Only the bench's scenarios can show the rest, which is the content of each response. It compares the computed addresses, including wraparound of the sum, with a behavioural model on every clock. It also covers the fault priority when several checks fail at once, the boundary values of limit and length, and a write and a request landing in the same cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef enum logic [2:0] {
    FLT_NONE,
    FLT_SEG_RANGE,
    FLT_SEG_INVALID,
    FLT_LIMIT,
    FLT_PERM
  } fault_e;

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT = 8,
  parameter int SEG_W   = 3,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 16,
  parameter int LEN_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_priv_i,
  input  logic             cfg_len_sel_i,
  input  logic [SEG_W-1:0] cfg_idx_i,
  input  logic [PA_W-1:0]  cfg_base_i,
  input  logic [OFF_W:0]   cfg_limit_i,
  input  logic             cfg_valid_i,
  input  perm_t            cfg_perm_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output logic [LEN_W-1:0] len_o,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [OFF_W:0]   rd_limit_o,
  output logic             rd_valid_o,
  output perm_t            rd_perm_o
);

  logic                  cfg_wr;
  logic [LEN_W-1:0]      len_q;
  logic [SEG_CNT-1:0][PA_W-1:0] base_all;
  logic [SEG_CNT-1:0][OFF_W:0]  limit_all;
  logic [SEG_CNT-1:0]           valid_all;
  perm_t [SEG_CNT-1:0]          perm_all;

  assign cfg_wr = cfg_we_i && cfg_priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     len_q <= '0;
    else if (cfg_wr && cfg_len_sel_i) len_q <= cfg_len_i;
  end

  for (genvar e = 0; e < SEG_CNT; e++) begin : g_ent
    logic [PA_W-1:0] base_q;
    logic [OFF_W:0]  limit_q;
    logic            valid_q;
    perm_t           perm_q;
    logic            hit;

    assign hit = cfg_wr && !cfg_len_sel_i && (cfg_idx_i == SEG_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q  <= '0;
        limit_q <= '0;
        valid_q <= 1'b0;
        perm_q  <= '0;
      end else if (hit) begin
        base_q  <= cfg_base_i;
        limit_q <= cfg_limit_i;
        valid_q <= cfg_valid_i;
        perm_q  <= cfg_perm_i;
      end
    end

    assign base_all[e]  = base_q;
    assign limit_all[e] = limit_q;
    assign valid_all[e] = valid_q;
    assign perm_all[e]  = perm_q;
  end

  always_comb begin
    if (int'(rd_idx_i) < SEG_CNT) begin
      rd_base_o  = base_all[rd_idx_i];
      rd_limit_o = limit_all[rd_idx_i];
      rd_valid_o = valid_all[rd_idx_i];
      rd_perm_o  = perm_all[rd_idx_i];
    end else begin
      rd_base_o  = '0;
      rd_limit_o = '0;
      rd_valid_o = 1'b0;
      rd_perm_o  = '0;
    end
  end

  assign len_o = len_q;

  assert_unpriv_ignored_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_priv_i) |=> $stable(len_q));

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  parameter int LEN_W = 4
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  acc_e             acc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ent_valid_i,
  input  perm_t            ent_perm_i,
  input  logic [PA_W-1:0]  ent_base_i,
  input  logic [OFF_W:0]   ent_limit_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  paddr_o
);

  logic allowed;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  allowed = ent_perm_i.r;
      ACC_WRITE: allowed = ent_perm_i.w;
      ACC_FETCH: allowed = ent_perm_i.x;
      default:   allowed = 1'b0;
    endcase
  end

  // priority: length, validation bit, limit, rights
  always_comb begin
    if (!(LEN_W'(seg_i) < len_i))              fault_o = FLT_SEG_RANGE;
    else if (!ent_valid_i)                      fault_o = FLT_SEG_INVALID;
    else if (!({1'b0, off_i} < ent_limit_i))    fault_o = FLT_LIMIT;
    else if (!allowed)                          fault_o = FLT_PERM;
    else                                        fault_o = FLT_NONE;
  end

  assign paddr_o = (fault_o == FLT_NONE) ? ent_base_i + PA_W'(off_i) : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_CNT = 8,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 16,
  localparam int SEG_W  = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1,
  localparam int LEN_W  = $clog2(SEG_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  input  logic             cfg_we_i,
  input  logic             cfg_priv_i,
  input  logic             cfg_len_sel_i,
  input  logic [SEG_W-1:0] cfg_idx_i,
  input  logic [PA_W-1:0]  cfg_base_i,
  input  logic [OFF_W:0]   cfg_limit_i,
  input  logic             cfg_valid_i,
  input  logic [2:0]       cfg_perm_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             fault_seg_o,
  output logic             fault_range_o,
  output logic             fault_perm_o
);

  logic [LEN_W-1:0] len;
  logic [PA_W-1:0]  ent_base;
  logic [OFF_W:0]   ent_limit;
  logic             ent_valid;
  perm_t            ent_perm;
  fault_e           fault;
  logic [PA_W-1:0]  paddr_c;

  seg_table #(
    .SEG_CNT(SEG_CNT), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_priv_i    (cfg_priv_i),
    .cfg_len_sel_i (cfg_len_sel_i),
    .cfg_idx_i     (cfg_idx_i),
    .cfg_base_i    (cfg_base_i),
    .cfg_limit_i   (cfg_limit_i),
    .cfg_valid_i   (cfg_valid_i),
    .cfg_perm_i    (perm_t'(cfg_perm_i)),
    .cfg_len_i     (cfg_len_i),
    .rd_idx_i      (req_seg_i),
    .len_o         (len),
    .rd_base_o     (ent_base),
    .rd_limit_o    (ent_limit),
    .rd_valid_o    (ent_valid),
    .rd_perm_o     (ent_perm)
  );

  seg_check #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_check (
    .seg_i       (req_seg_i),
    .off_i       (req_off_i),
    .acc_i       (acc_e'(req_acc_i)),
    .len_i       (len),
    .ent_valid_i (ent_valid),
    .ent_perm_i  (ent_perm),
    .ent_base_i  (ent_base),
    .ent_limit_i (ent_limit),
    .fault_o     (fault),
    .paddr_o     (paddr_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_paddr_o   <= '0;
      fault_seg_o   <= 1'b0;
      fault_range_o <= 1'b0;
      fault_perm_o  <= 1'b0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_paddr_o   <= req_valid_i ? paddr_c : '0;
      fault_seg_o   <= req_valid_i && (fault == FLT_SEG_RANGE || fault == FLT_SEG_INVALID);
      fault_range_o <= req_valid_i && (fault == FLT_LIMIT);
      fault_perm_o  <= req_valid_i && (fault == FLT_PERM);
    end
  end

  assert_rsp_follows_req_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_quiet_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !fault_seg_o && !fault_range_o && !fault_perm_o);

  assert_one_fault_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_seg_o, fault_range_o, fault_perm_o}));

  assert_fault_zero_addr_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_seg_o || fault_range_o || fault_perm_o) |-> (rsp_paddr_o == '0) && rsp_valid_o);

  assert_len_bound_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(LEN_W'(req_seg_i) < len)) |=> fault_seg_o);

endmodule

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
  localparam int SEG_CNT = 8;
  localparam int SEG_W   = 3;
  localparam int OFF_W   = 12;
  localparam int PA_W    = 16;
  localparam int LEN_W   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid_i = 0;
  logic [SEG_W-1:0] req_seg_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [1:0]       req_acc_i = '0;
  logic             cfg_we_i = 0, cfg_priv_i = 0, cfg_len_sel_i = 0, cfg_valid_i = 0;
  logic [SEG_W-1:0] cfg_idx_i = '0;
  logic [PA_W-1:0]  cfg_base_i = '0;
  logic [OFF_W:0]   cfg_limit_i = '0;
  logic [2:0]       cfg_perm_i = '0;
  logic [LEN_W-1:0] cfg_len_i = '0;
  logic             rsp_valid_o, fault_seg_o, fault_range_o, fault_perm_o;
  logic [PA_W-1:0]  rsp_paddr_o;

  seg_xlate_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_seg_i(req_seg_i), .req_off_i(req_off_i), .req_acc_i(req_acc_i),
    .cfg_we_i(cfg_we_i), .cfg_priv_i(cfg_priv_i), .cfg_len_sel_i(cfg_len_sel_i),
    .cfg_idx_i(cfg_idx_i), .cfg_base_i(cfg_base_i), .cfg_limit_i(cfg_limit_i),
    .cfg_valid_i(cfg_valid_i), .cfg_perm_i(cfg_perm_i), .cfg_len_i(cfg_len_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o),
    .fault_seg_o(fault_seg_o), .fault_range_o(fault_range_o), .fault_perm_o(fault_perm_o)
  );

  int n_chk = 0, n_bad = 0;

  // behavioural model state
  int m_len;
  int m_base [SEG_CNT];
  int m_lim  [SEG_CNT];
  bit m_val  [SEG_CNT];
  bit [2:0] m_perm [SEG_CNT];

  task automatic model_reset();
    m_len = 0;
    for (int i = 0; i < SEG_CNT; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_val[i] = 0; m_perm[i] = 0;
    end
  endtask

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (valid,seg,range,perm,paddr)", tag, act, exp);
    end
  endtask

  // one clock: predict from pre-edge model, update model, compare after edge
  task automatic step(string extra = "");
    logic ev, efs, efr, efp;
    logic [15:0] epa;
    string tag;
    ev = 0; efs = 0; efr = 0; efp = 0; epa = 0; tag = "R2 idle";
    if (req_valid_i) begin
      int s, o, a;
      s = int'(req_seg_i); o = int'(req_off_i); a = int'(req_acc_i);
      ev = 1;
      if (s >= m_len) begin efs = 1; tag = "R3/R8 length"; end
      else if (!m_val[s]) begin efs = 1; tag = "R4/R8 invalid"; end
      else if (o >= m_lim[s]) begin efr = 1; tag = "R5/R8 limit"; end
      else if (a == 3 || !m_perm[s][a]) begin efp = 1; tag = "R6/R8 rights"; end
      else begin epa = 16'((m_base[s] + o) % 65536); tag = "R7 translate"; end
    end
    if (cfg_we_i && cfg_priv_i) begin
      if (cfg_len_sel_i) m_len = int'(cfg_len_i);
      else begin
        m_base[cfg_idx_i] = int'(cfg_base_i);
        m_lim[cfg_idx_i]  = int'(cfg_limit_i);
        m_val[cfg_idx_i]  = cfg_valid_i;
        m_perm[cfg_idx_i] = cfg_perm_i;
      end
    end
    @(posedge clk); #1;
    check({extra, tag}, {rsp_valid_o, fault_seg_o, fault_range_o, fault_perm_o, rsp_paddr_o},
          {ev, efs, efr, efp, epa});
    @(negedge clk);
  endtask

  task automatic idle_in();
    req_valid_i = 0; cfg_we_i = 0;
  endtask

  task automatic wr_len(int len, bit priv, string extra = "");
    idle_in();
    cfg_we_i = 1; cfg_priv_i = priv; cfg_len_sel_i = 1; cfg_len_i = LEN_W'(len);
    step(extra);
    cfg_we_i = 0;
  endtask

  task automatic wr_ent(int idx, int base, int lim, bit val, bit [2:0] perm, bit priv, string extra = "");
    idle_in();
    cfg_we_i = 1; cfg_priv_i = priv; cfg_len_sel_i = 0; cfg_idx_i = SEG_W'(idx);
    cfg_base_i = PA_W'(base); cfg_limit_i = 13'(lim); cfg_valid_i = val; cfg_perm_i = perm;
    step(extra);
    cfg_we_i = 0;
  endtask

  task automatic req(int seg, int off, int acc, string extra = "");
    req_valid_i = 1; req_seg_i = SEG_W'(seg); req_off_i = OFF_W'(off); req_acc_i = 2'(acc);
    step(extra);
    req_valid_i = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    // R1: outputs held low in reset
    req_valid_i = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", {rsp_valid_o, fault_seg_o, fault_range_o, fault_perm_o, rsp_paddr_o}, 20'h0);
    req_valid_i = 0;
    rst_ni = 1;
    @(negedge clk);
    check("R1 after release", {rsp_valid_o, fault_seg_o, fault_range_o, fault_perm_o, rsp_paddr_o}, 20'h0);
    req(0, 0, 0, "R1 ");                       // length 0 after reset -> segment fault

    // R9: unprivileged writes ignored
    wr_len(8, 0, "R9 ");
    wr_ent(0, 16'h1000, 100, 1, 3'b111, 0, "R9 ");
    req(0, 5, 0, "R9 ");                       // still length fault
    wr_len(8, 1);
    req(0, 5, 0, "R9 ");                       // now entry invalid (R4)

    wr_ent(0, 16'h1000, 100, 1, 3'b001, 1);     // read only
    wr_ent(1, 16'hFFF0, 4096, 1, 3'b110, 1);    // write+fetch, max limit
    wr_ent(7, 16'h0200, 1, 1, 3'b100, 1);       // fetch only, limit 1
    req(0, 0, 0);                               // R7
    req(0, 99, 0, "R5 edge ");                  // last legal offset
    req(0, 100, 0, "R5 edge ");                 // limit fault
    req(0, 10, 1);                              // R6 write denied
    req(0, 10, 3);                              // R6 reserved code
    req(1, 32, 1, "R7 wrap ");                  // FFF0+20 -> 0010
    req(1, 4095, 2);                            // R7 fetch
    req(1, 5, 0);                               // R6 read denied
    req(7, 0, 2, "R10 ");                       // segment 7 legal at length 8
    req(7, 1, 0, "R8 limit over rights ");      // limit beats rights
    req(3, 0, 3, "R8 invalid over rights ");    // invalid beats rights
    wr_len(7, 1);
    req(7, 0, 2, "R10 ");                       // segment 7 now beyond length

    // R9: write and request in the same cycle see old contents
    req_valid_i = 1; req_seg_i = 0; req_off_i = 12'd5; req_acc_i = 2'd1;
    cfg_we_i = 1; cfg_priv_i = 1; cfg_len_sel_i = 0; cfg_idx_i = 0;
    cfg_base_i = 16'h3000; cfg_limit_i = 13'd50; cfg_valid_i = 1; cfg_perm_i = 3'b011;
    step("R9 same cycle ");
    idle_in();
    req(0, 5, 1, "R9 after ");

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      req_valid_i   = ($urandom_range(3) != 0);
      req_seg_i     = SEG_W'($urandom_range(SEG_CNT - 1));
      req_off_i     = ($urandom_range(1) == 0) ? OFF_W'($urandom_range(64)) : OFF_W'($urandom);
      req_acc_i     = 2'($urandom_range(3));
      cfg_we_i      = ($urandom_range(9) == 0);
      cfg_priv_i    = ($urandom_range(9) < 7);
      cfg_len_sel_i = ($urandom_range(3) == 0);
      cfg_len_i     = LEN_W'($urandom_range(SEG_CNT));
      cfg_idx_i     = SEG_W'($urandom_range(SEG_CNT - 1));
      cfg_base_i    = PA_W'($urandom);
      cfg_limit_i   = ($urandom_range(1) == 0) ? 13'($urandom_range(64)) : 13'($urandom_range(4096));
      cfg_valid_i   = ($urandom_range(4) != 0);
      cfg_perm_i    = 3'($urandom);
      step("mix ");
    end
    idle_in();
    step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule